// File: doc/BRIEF.md
# Special Register File with Exception Save and Restore

This block holds a processor's special registers and its two fetch program counters: the delayed PC and the PC-prime that follows it. The special registers are status, saved status, exception cause, saved PC, saved delayed PC, exception data, rounding mode, IEEE sticky flags and the floating-point condition code. Decode and next-PC logic outside the block supply one instruction's worth of controls per step, together with the interrupt decision. Each enabled clock edge applies either the ordinary per-instruction update or the interrupt save sequence.

Interrupts come in two classes. A repeat interrupt saves the state from before the instruction, so the instruction runs again after the handler returns. A continue interrupt saves the state that the instruction would have produced, so execution resumes after it. The IEEE sticky flags take the FPU exception bits of every floating-point-class instruction. A repeat interrupt suppresses this merge.

Top module: `xcpt_spr_file`

## Requirements
- R1: During reset the delayed PC is HANDLER_PC and PC-prime is HANDLER_PC+4. Every special register then reads zero. The register indices are 0 status, 1 saved status, 2 cause, 3 saved PC, 4 saved delayed PC, 5 exception data, 6 rounding mode, 7 sticky flags and 8 condition code.
- R2: While step_en is low, neither the registers nor the PCs change, whatever the other controls are.
- R3: If no interrupt is taken, return-from-exception copies saved status (index 1) into status (index 0) and loads the delayed PC from saved delayed PC (index 4).
- R4: Move-to-special writes mts_data to the register at mts_idx when that index is 8 or less. A higher index writes nothing, and reading any index above 8 returns zero.
- R5: If no interrupt is taken, an FP compare writes fcmp_result into the condition code (index 8).
- R6: If no interrupt is taken and the instruction is not a return-from-exception, the delayed PC takes the old PC-prime and PC-prime takes next_pcp_in.
- R7: On a taken interrupt, status becomes zero, cause takes masked_cause, exception data takes xdata_in, the delayed PC becomes HANDLER_PC and PC-prime becomes HANDLER_PC+4.
- R8: On a repeat interrupt, saved status, saved PC and saved delayed PC take the current status, PC-prime and delayed PC. The other registers do not change.
- R9: On a continue interrupt, saved status, saved PC and saved delayed PC take the status, next_pcp_in and delayed PC that the normal update would produce. The other registers take their normal-update values.
- R10: For an FP-class instruction, bits 4:0 of the sticky flags are ORed with fpu_exc[11:7] and bits 31:5 are kept. No merge happens when a repeat interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Applies one instruction step at this edge |
| irq_taken | input | 1 | An interrupt is taken in this step |
| irq_repeat | input | 1 | The taken interrupt is of the repeat class |
| masked_cause | input | 32 | Masked cause vector |
| xdata_in | input | 32 | Selected exception data |
| is_rfe | input | 1 | Return-from-exception instruction |
| is_mts | input | 1 | Move-to-special instruction |
| mts_idx | input | 5 | Target index of move-to-special |
| mts_data | input | 32 | Operand of move-to-special |
| is_fcmp | input | 1 | FP compare instruction |
| fcmp_result | input | 32 | Low word of the FP compare result |
| is_fpclass | input | 1 | FP-class instruction that merges the sticky flags |
| fpu_exc | input | 32 | FPU exception vector |
| next_pcp_in | input | 32 | Next PC-prime from the normal flow |
| rd_idx | input | 5 | Read index |
| rd_data | output | 32 | Read data, zero for an unimplemented index |
| dpc | output | 32 | Delayed PC |
| pcp | output | 32 | PC-prime |

## Verification
A wrong save choice in this block stays hidden until it is read back. A saved delayed PC or saved status taken from the wrong class is only visible on the read port at a later read, or on the delayed PC after the next return-from-exception. The PCs show a bad interrupt or step decision one edge after that decision. A lost or spurious sticky-flag merge, or a move-to-special that is not ignored, only appears when that register is read back. For this reason the bench reads back every register that a step could have touched.

// File: rtl/xcpt_spr_file.sv
module xcpt_spr_file #(
  parameter int XLEN = 32,
  parameter int IDXW = 5,
  parameter int NREG = 9,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            irq_taken,
  input  logic            irq_repeat,
  input  logic [XLEN-1:0] masked_cause,
  input  logic [XLEN-1:0] xdata_in,
  input  logic            is_rfe,
  input  logic            is_mts,
  input  logic [IDXW-1:0] mts_idx,
  input  logic [XLEN-1:0] mts_data,
  input  logic            is_fcmp,
  input  logic [XLEN-1:0] fcmp_result,
  input  logic            is_fpclass,
  input  logic [XLEN-1:0] fpu_exc,
  input  logic [XLEN-1:0] next_pcp_in,
  input  logic [IDXW-1:0] rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] dpc,
  output logic [XLEN-1:0] pcp
);
  localparam int ST = 0, SST = 1, CAU = 2, SPC = 3, SDPC = 4;
  localparam int XD = 5, FLG = 7, FCC = 8;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG - 1);
  localparam logic [XLEN-1:0] H0 = XLEN'(HANDLER_PC);
  localparam logic [XLEN-1:0] H1 = XLEN'(HANDLER_PC) + XLEN'(INSN_BYTES);

  logic [XLEN-1:0] sr [NREG];
  logic [XLEN-1:0] nu [NREG];
  logic [XLEN-1:0] nx [NREG];
  logic [XLEN-1:0] dpc_q, pcp_q, nu_dpc;
  logic            rep;

  assign rep    = irq_taken && irq_repeat;
  assign nu_dpc = is_rfe ? sr[SDPC] : pcp_q;
  assign dpc    = dpc_q;
  assign pcp    = pcp_q;

  always_comb begin
    for (int i = 0; i < NREG; i++) nu[i] = sr[i];
    if (is_rfe) nu[ST] = sr[SST];
    else if (is_mts && mts_idx <= LAST_IDX) begin
      for (int i = 0; i < NREG; i++)
        if (mts_idx == IDXW'(i)) nu[i] = mts_data;
    end else if (is_fcmp) nu[FCC] = fcmp_result;

    for (int i = 0; i < NREG; i++) nx[i] = rep ? sr[i] : nu[i];
    if (irq_taken) begin
      nx[ST]   = '0;
      nx[CAU]  = masked_cause;
      nx[XD]   = xdata_in;
      nx[SST]  = rep ? sr[ST] : nu[ST];
      nx[SPC]  = rep ? pcp_q  : next_pcp_in;
      nx[SDPC] = rep ? dpc_q  : nu_dpc;
    end
    if (is_fpclass && !rep) nx[FLG][4:0] = nx[FLG][4:0] | fpu_exc[11:7];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDXW'(i)) rd_data = sr[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) sr[i] <= '0;
      dpc_q <= H0;
      pcp_q <= H1;
    end else if (step_en) begin
      for (int i = 0; i < NREG; i++) sr[i] <= nx[i];
      dpc_q <= irq_taken ? H0 : nu_dpc;
      pcp_q <= irq_taken ? H1 : next_pcp_in;
    end
  end
endmodule

module xcpt_spr_file_chk #(
  parameter int XLEN = 32,
  parameter int IDXW = 5,
  parameter int NREG = 9,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100,
  parameter int INSN_BYTES = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            step_en,
  input logic            irq_taken,
  input logic            irq_repeat,
  input logic            is_rfe,
  input logic [IDXW-1:0] rd_idx,
  input logic [XLEN-1:0] rd_data,
  input logic [XLEN-1:0] dpc,
  input logic [XLEN-1:0] pcp,
  input logic [XLEN-1:0] sdpc_q
);
  localparam logic [XLEN-1:0] H0 = XLEN'(HANDLER_PC);
  localparam logic [XLEN-1:0] H1 = XLEN'(HANDLER_PC) + XLEN'(INSN_BYTES);

  AST_RESET_PCS: assert property (@(posedge clk) rst |=> (dpc == H0 && pcp == H1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !step_en |=> ($stable(dpc) && $stable(pcp))); // R2
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_idx > IDXW'(NREG - 1)) |-> rd_data == '0); // R4
  AST_SEQ_FLOW: assert property (@(posedge clk) disable iff (rst) (step_en && !irq_taken && !is_rfe) |=> dpc == $past(pcp)); // R6
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst) (step_en && irq_taken) |=> (dpc == H0 && pcp == H1)); // R7
  AST_REPEAT_SAVE: assert property (@(posedge clk) disable iff (rst) (step_en && irq_taken && irq_repeat) |=> sdpc_q == $past(dpc)); // R8
endmodule

bind xcpt_spr_file xcpt_spr_file_chk #(
  .XLEN(XLEN), .IDXW(IDXW), .NREG(NREG), .HANDLER_PC(HANDLER_PC), .INSN_BYTES(INSN_BYTES)
) chk_i (
  .clk(clk), .rst(rst), .step_en(step_en), .irq_taken(irq_taken), .irq_repeat(irq_repeat),
  .is_rfe(is_rfe), .rd_idx(rd_idx), .rd_data(rd_data), .dpc(dpc), .pcp(pcp), .sdpc_q(sr[4])
);

// File: tb/xcpt_spr_file_tb_top.sv
module xcpt_spr_file_tb_top;
  logic clk = 0, rst = 1, step_en = 0, irq_taken = 0, irq_repeat = 0;
  logic is_rfe = 0, is_mts = 0, is_fcmp = 0, is_fpclass = 0;
  logic [31:0] masked_cause = 0, xdata_in = 0, mts_data = 0, fcmp_result = 0, fpu_exc = 0, next_pcp_in = 0;
  logic [4:0] mts_idx = 0, rd_idx = 0;
  logic [31:0] rd_data, dpc, pcp;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xcpt_spr_file dut_i (.*);

  typedef struct { int kind; logic [4:0] idx; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  task automatic expect_reg(input logic [4:0] idx, input logic [31:0] exp, input string tag);
    sbq.push_back('{0, idx, exp, tag});
  endtask
  task automatic expect_pc(input logic [31:0] d, input logic [31:0] p, input string tag);
    sbq.push_back('{1, 5'd0, d, tag});
    sbq.push_back('{2, 5'd0, p, tag});
  endtask
  task automatic drain;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        rd_idx = it.idx;
        #2;
        act = (it.kind == 0) ? rd_data : (it.kind == 1) ? dpc : pcp;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.tag, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic clear_ctl;
    irq_taken = 0; irq_repeat = 0; is_rfe = 0; is_mts = 0; is_fcmp = 0; is_fpclass = 0;
  endtask
  task automatic step(input logic [31:0] nxt);
    @(negedge clk);
    next_pcp_in = nxt;
    step_en = 1;
    @(negedge clk);
    step_en = 0;
    clear_ctl();
  endtask
  task automatic mts(input logic [4:0] idx, input logic [31:0] d, input logic [31:0] nxt);
    @(negedge clk);
    is_mts = 1; mts_idx = idx; mts_data = d;
    step(nxt);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    expect_pc(32'h100, 32'h104, "R1 reset pcs");
    expect_reg(0, 0, "R1 status"); expect_reg(2, 0, "R1 cause"); expect_reg(7, 0, "R1 flags");
    rst = 0;
    drain();

    mts(1, 32'hA5, 32'h108);
    expect_pc(32'h104, 32'h108, "R6 sequential");
    expect_reg(1, 32'hA5, "R4 mts saved status");
    drain();
    mts(4, 32'h2000, 32'h10C);
    mts(9, 32'h55, 32'h110);
    expect_reg(9, 0, "R4 unimplemented read");
    expect_reg(31, 0, "R4 top index read");
    expect_reg(1, 32'hA5, "R4 ignored write");
    expect_reg(4, 32'h2000, "R4 mts saved dpc");
    drain();

    @(negedge clk); is_fcmp = 1; fcmp_result = 32'h1;
    step(32'h114);
    expect_reg(8, 32'h1, "R5 fcmp");
    drain();

    mts(7, 32'hFFFF_FFE0, 32'h118);
    @(negedge clk); is_fpclass = 1; fpu_exc = 32'h0000_0980;
    step(32'h11C);
    expect_reg(7, 32'hFFFF_FFF3, "R10 sticky merge");
    drain();

    @(negedge clk); is_rfe = 1;
    step(32'h2004);
    expect_reg(0, 32'hA5, "R3 rfe status");
    expect_pc(32'h2000, 32'h2004, "R3 rfe pcs");
    drain();

    @(negedge clk); is_mts = 1; mts_idx = 6; mts_data = 32'h7; irq_taken = 1;
    @(negedge clk); @(negedge clk); clear_ctl();
    expect_reg(6, 0, "R2 idle no write");
    expect_reg(0, 32'hA5, "R2 idle status");
    expect_pc(32'h2000, 32'h2004, "R2 idle pcs");
    drain();

    @(negedge clk);
    irq_taken = 1; irq_repeat = 1; masked_cause = 32'h10; xdata_in = 32'hDEAD;
    is_mts = 1; mts_idx = 6; mts_data = 32'h7; is_fpclass = 1; fpu_exc = 32'h0000_0200;
    step(32'h9000);
    expect_pc(32'h100, 32'h104, "R7 vector");
    expect_reg(0, 0, "R7 status cleared");
    expect_reg(2, 32'h10, "R7 cause");
    expect_reg(5, 32'hDEAD, "R7 xdata");
    expect_reg(1, 32'hA5, "R8 saved status");
    expect_reg(3, 32'h2004, "R8 saved pc");
    expect_reg(4, 32'h2000, "R8 saved dpc");
    expect_reg(6, 0, "R8 rm held");
    expect_reg(7, 32'hFFFF_FFF3, "R10 merge skipped on repeat");
    drain();

    @(negedge clk);
    irq_taken = 1; masked_cause = 32'h40; xdata_in = 32'hBEEF;
    is_mts = 1; mts_idx = 6; mts_data = 32'h7; is_fpclass = 1; fpu_exc = 32'h0000_0200;
    step(32'h500);
    expect_reg(1, 0, "R9 saved status");
    expect_reg(3, 32'h500, "R9 saved pc");
    expect_reg(4, 32'h104, "R9 saved dpc");
    expect_reg(6, 32'h7, "R9 rm normal update");
    expect_reg(7, 32'hFFFF_FFF7, "R10 merge on continue");
    expect_reg(2, 32'h40, "R7 cause continue");
    expect_reg(5, 32'hBEEF, "R7 xdata continue");
    expect_pc(32'h100, 32'h104, "R7 vector continue");
    drain();

    mts(0, 32'h77, 32'h600);
    mts(1, 32'h33, 32'h700);
    @(negedge clk); irq_taken = 1; is_rfe = 1; masked_cause = 32'h80;
    step(32'h800);
    expect_reg(1, 32'h33, "R9 saved status via rfe");
    expect_reg(4, 32'h104, "R9 saved dpc via rfe");
    expect_reg(3, 32'h800, "R9 saved pc via rfe");
    expect_reg(0, 0, "R7 status cleared again");
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule